// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns bytes into asynchronous serial frames on one output line. Each byte enters through a valid/ready stream port. When a byte is accepted, the block sends a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then stop time at the idle level. Every bit lasts a number of clock cycles set by a 20-bit divisor, so the bit rate is the clock frequency divided by that divisor. Divisor values below 16 are raised to 16.

The frame format is sampled at the moment a byte is accepted and is held until that frame ends. This covers data length, stop length, parity, line inversion and divisor. A change to any of these pins only affects later frames. An optional clear-to-send input can hold back new frames. It is looked at only when a frame is about to start, so a frame that has begun always runs to its end. Separate inversion bits flip the level of the output line and of the clear-to-send input.

Back-pressure rules: `in_ready` is high only while no frame is in flight and, with flow control on, the clear-to-send input reads as clear. A byte is taken on a rising edge where `in_valid` and `in_ready` are both high. The source may hold `in_valid` high for as long as it likes without any side effect. In the cycle after the last stop cycle, `in_ready` can already be high again, so frames can follow each other with no idle gap.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, with `line_inv` low, `txd` is 1, `busy` is 0 and `in_ready` is 1.
- R2: A frame is a start bit at level 0, then data bits with the least significant bit first. Each start, data and parity bit lasts exactly D cycles, where D is the effective divisor. The start bit begins in the cycle right after the accepting edge.
- R3: `data_len` selects the number of data bits: code 0 gives 5, code 1 gives 6, code 2 gives 7 and code 3 gives 8. The upper bits of `in_data` that are not sent have no effect on the line.
- R4: When `par_en` is 1, a parity bit follows the last data bit. With `par_odd` at 0 it makes the count of ones in the data bits plus the parity bit even; with `par_odd` at 1 it makes that count odd. When `par_en` is 0, no parity bit is sent.
- R5: The stop time is at level 1 and depends on `stop_len`. Code 1 gives D cycles, code 2 gives D + floor(D/2) cycles and code 3 gives 2·D cycles. Code 0 is treated like code 1. `busy` falls exactly when the stop time ends.
- R6: The effective divisor D equals `clk_div` when `clk_div` is 16 or more. Below 16, D is 16.
- R7: When `line_inv` is 1, every level on `txd` is inverted, both idle and within a frame.
- R8: When `flow_en` is 1, clear-to-send is asserted when `cts_n` XOR `cts_inv` equals 0. While it is not asserted, `in_ready` stays 0, and a held `in_valid` starts no frame, so `busy` stays 0 and `txd` stays idle.
- R9: A change of `cts_n` after a frame has started does not shorten, stretch or alter that frame.
- R10: A change to `data_len`, `stop_len`, `par_en`, `par_odd` or `clk_div` during a frame has no effect on that frame.
- R11: `in_ready` is never high while `busy` is high. `busy` is high from the cycle after acceptance through the last stop cycle. `in_ready` may be high in the cycle after the last stop cycle, which allows back-to-back frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be taken this cycle |
| clk_div | input | 20 | Cycles per bit (clamped to at least 16) |
| data_len | input | 2 | Data length code (0..3 gives 5..8 bits) |
| stop_len | input | 2 | Stop length code (1: one, 2: one and a half, 3: two) |
| par_en | input | 1 | Add a parity bit |
| par_odd | input | 1 | 0 selects even parity, 1 selects odd |
| line_inv | input | 1 | Invert the output line |
| flow_en | input | 1 | Gate frame starts with clear-to-send |
| cts_n | input | 1 | Clear-to-send level (clear when 0 after inversion) |
| cts_inv | input | 1 | Invert the clear-to-send level |
| txd | output | 1 | Serial output |
| busy | output | 1 | Frame in flight |

## Verification
The assertions assume the following:
- every input is synchronous to `clk`, including `cts_n`, which has no synchroniser inside the block;
- reset is asserted before the first edge, so the latched frame format and the state start from known values.

The bench respects these assumptions. It changes every input, the clear-to-send level included, only on falling clock edges, and it holds reset low over the first edges. Random frames draw divisors from a narrow range near the clamp limit, which keeps each frame short enough to check every cycle.

// File: rtl/uft_pkg.sv
package uft_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       inv;
  } frame_cfg_t;

  localparam logic [1:0] STOP_ONE_HALF = 2'd2;
  localparam logic [1:0] STOP_TWO      = 2'd3;
endpackage

// File: rtl/uft_div_prep.sv
module uft_div_prep #(
  parameter int DIV_W   = 20,
  parameter int MIN_DIV = 16,
  localparam int LEN_W  = DIV_W + 1
) (
  input  logic [DIV_W-1:0] div_raw,
  input  logic [1:0]       stop_code,
  output logic [LEN_W-1:0] bit_cyc,
  output logic [LEN_W-1:0] stop_cyc
);
  import uft_pkg::*;

  logic [LEN_W-1:0] div_eff;

  always_comb begin
    if (div_raw < DIV_W'(MIN_DIV)) div_eff = LEN_W'(MIN_DIV);
    else                           div_eff = {1'b0, div_raw};
    bit_cyc = div_eff;
    case (stop_code)
      STOP_ONE_HALF: stop_cyc = div_eff + (div_eff >> 1);
      STOP_TWO:      stop_cyc = div_eff << 1;
      default:       stop_cyc = div_eff;
    endcase
  end
endmodule

// File: rtl/uft_parity.sv
module uft_parity #(
  parameter int DATA_W = 8,
  parameter int MIN_BITS = 5
) (
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        len_code,
  input  logic              odd,
  output logic              par_bit
);
  logic [DATA_W-1:0] masked;
  int unsigned       nbits;

  assign nbits = MIN_BITS + int'(len_code);

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign masked[g] = data[g] & (g < nbits);
  end

  assign par_bit = (^masked) ^ odd;
endmodule

// File: rtl/uft_bit_timer.sv
module uft_bit_timer #(
  parameter int LEN_W   = 21,
  parameter int MIN_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  output logic             last
);
  logic [LEN_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= len;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign last = (cnt == LEN_W'(1));

  // R6
  min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> len >= LEN_W'(MIN_LEN));
endmodule

// File: rtl/uft_tx_core.sv
module uft_tx_core #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] data,
  input  uft_pkg::frame_cfg_t cfg,
  input  logic              par_bit,
  input  logic [LEN_W-1:0]  bit_cyc,
  input  logic [LEN_W-1:0]  stop_cyc,
  input  logic              t_last,
  output logic              t_load,
  output logic [LEN_W-1:0]  t_len,
  output logic              level,
  output logic              busy,
  output logic              inv_q
);
  import uft_pkg::*;

  tx_state_e         state;
  frame_cfg_t        cfg_q;
  logic [DATA_W-1:0] shreg;
  logic [2:0]        bitcnt;
  logic              par_q;
  logic [LEN_W-1:0]  bit_q, stop_q;
  logic [2:0]        last_idx;

  assign last_idx = {1'b1, cfg_q.len};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cfg_q  <= '0;
      shreg  <= '0;
      bitcnt <= '0;
      par_q  <= 1'b0;
      bit_q  <= '0;
      stop_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state  <= ST_START;
          cfg_q  <= cfg;
          shreg  <= data;
          par_q  <= par_bit;
          bit_q  <= bit_cyc;
          stop_q <= stop_cyc;
        end
        ST_START: if (t_last) begin
          state  <= ST_DATA;
          bitcnt <= '0;
        end
        ST_DATA: if (t_last) begin
          shreg <= shreg >> 1;
          if (bitcnt == last_idx) state <= cfg_q.par_en ? ST_PAR : ST_STOP;
          else                    bitcnt <= bitcnt + 1'b1;
        end
        ST_PAR:  if (t_last) state <= ST_STOP;
        ST_STOP: if (t_last) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    t_load = 1'b0;
    t_len  = bit_q;
    case (state)
      ST_IDLE: begin
        t_load = accept;
        t_len  = bit_cyc;
      end
      ST_START: t_load = t_last;
      ST_DATA: begin
        t_load = t_last;
        if (bitcnt == last_idx && !cfg_q.par_en) t_len = stop_q;
      end
      ST_PAR: begin
        t_load = t_last;
        t_len  = stop_q;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (state)
      ST_START: level = 1'b0;
      ST_DATA:  level = shreg[0];
      ST_PAR:   level = par_q;
      default:  level = 1'b1;
    endcase
  end

  assign busy  = (state != ST_IDLE);
  assign inv_q = cfg_q.inv;

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(cfg_q) && $stable(stop_q) && $stable(bit_q)));
  // R3
  bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> (bitcnt <= last_idx));
  // R5
  stop_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(state) == ST_STOP));
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 20,
  parameter int MIN_DIV = 16,
  localparam int LEN_W  = DIV_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [1:0]        data_len,
  input  logic [1:0]        stop_len,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              line_inv,
  input  logic              flow_en,
  input  logic              cts_n,
  input  logic              cts_inv,
  output logic              txd,
  output logic              busy
);
  import uft_pkg::*;

  logic             accept, cts_clear, par_bit, t_load, t_last, level, inv_q;
  logic [LEN_W-1:0] bit_cyc, stop_cyc, t_len;
  frame_cfg_t       cfg;

  assign cts_clear = ((cts_n ^ cts_inv) == 1'b0);
  assign in_ready  = !busy && (!flow_en || cts_clear);
  assign accept    = in_valid && in_ready;
  assign cfg       = '{len: data_len, par_en: par_en, inv: line_inv};

  uft_div_prep #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_prep (
    .div_raw(clk_div), .stop_code(stop_len), .bit_cyc(bit_cyc), .stop_cyc(stop_cyc));

  uft_parity #(.DATA_W(DATA_W)) u_par (
    .data(in_data), .len_code(data_len), .odd(par_odd), .par_bit(par_bit));

  uft_bit_timer #(.LEN_W(LEN_W), .MIN_LEN(MIN_DIV)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(t_load), .len(t_len), .last(t_last));

  uft_tx_core #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_core (
    .clk(clk), .rst_n(rst_n), .accept(accept), .data(in_data), .cfg(cfg),
    .par_bit(par_bit), .bit_cyc(bit_cyc), .stop_cyc(stop_cyc), .t_last(t_last),
    .t_load(t_load), .t_len(t_len), .level(level), .busy(busy), .inv_q(inv_q));

  assign txd = level ^ (busy ? inv_q : line_inv);

  // R11
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !busy);
  // R11
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R8
  flow_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && (cts_n ^ cts_inv) && !busy) |=> !busy);
  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (txd == inv_q));
endmodule

// File: tb/sim_uart_frame_tx.sv
`timescale 1ns/1ps
module sim_uart_frame_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [19:0] clk_div = 20'd16;
  logic [1:0]  data_len = 2'd3;
  logic [1:0]  stop_len = 2'd1;
  logic        par_en = 1'b0, par_odd = 1'b0, line_inv = 1'b0;
  logic        flow_en = 1'b0, cts_n = 1'b0, cts_inv = 1'b0;
  logic        txd, busy;
  int          vectors = 0, fails = 0;

  always #10 clk = ~clk;

  uart_frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .clk_div(clk_div), .data_len(data_len), .stop_len(stop_len), .par_en(par_en),
    .par_odd(par_odd), .line_inv(line_inv), .flow_en(flow_en), .cts_n(cts_n),
    .cts_inv(cts_inv), .txd(txd), .busy(busy));

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic int eff_div(input logic [19:0] d);
    return (d < 20'd16) ? 16 : int'(d);
  endfunction

  function automatic int stop_cycles(input int d, input logic [1:0] code);
    if (code == 2'd2) return d + d / 2;
    if (code == 2'd3) return 2 * d;
    return d;
  endfunction

  function automatic bit cts_ok();
    return !flow_en || ((cts_n ^ cts_inv) == 1'b0);
  endfunction

  // act: 0 none, 1 block clear-to-send mid-frame (R9), 2 change format mid-frame (R10)
  task automatic run_frame(input logic [7:0] d, input int act, input string rq);
    int nb = int'(data_len) + 5;
    int de = eff_div(clk_div);
    int sc = stop_cycles(de, stop_len);
    bit inv = line_inv;
    logic [10:0] fb = '1;
    int nf, total, bad_i;
    logic [2:0] bad_act, bad_exp;
    bit pb = par_odd;
    fb[0] = 1'b0;
    for (int k = 0; k < nb; k++) begin
      fb[k+1] = d[k];
      pb ^= d[k];
    end
    nf = nb + 1;
    if (par_en) begin
      fb[nf] = pb;
      nf++;
    end
    total = nf * de + sc;
    bad_i = -1;
    bad_act = '0;
    bad_exp = '0;
    in_data = d;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_data = ~d;
    for (int i = 0; i <= total; i++) begin
      logic lvl = (i < nf * de) ? fb[i / de] : 1'b1;
      logic [2:0] e, a;
      e = {(i == total) ? cts_ok() : 1'b0, i < total, lvl ^ ((i == total) ? line_inv : inv)};
      a = {in_ready, busy, txd};
      if (a !== e && bad_i < 0) begin
        bad_i = i;
        bad_act = a;
        bad_exp = e;
      end
      if (i == 5 && act == 1) cts_n = ~cts_n;
      if (i == 5 && act == 2) begin
        data_len = ~data_len;
        stop_len = (stop_len == 2'd3) ? 2'd1 : 2'd3;
        par_en = ~par_en;
        par_odd = ~par_odd;
        clk_div = clk_div + 20'd7;
      end
      @(negedge clk);
    end
    check(bad_i < 0, rq, $sformatf("frame d=%0h cycle %0d {ready,busy,txd}", d, bad_i),
          bad_act, bad_exp);
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({txd, busy, in_ready} === 3'b101, "R1", "{txd,busy,ready} after reset",
          {txd, busy, in_ready}, 3'b101);

    // R2 R3 basic 8N1 frame
    run_frame(8'hA5, 0, "R2 R3");
    // R3 five data bits, upper bits ignored
    data_len = 2'd0;
    run_frame(8'hE6, 0, "R3");
    // R4 even and odd parity
    data_len = 2'd3; par_en = 1'b1; par_odd = 1'b0;
    run_frame(8'h07, 0, "R4 even");
    par_odd = 1'b1;
    run_frame(8'h07, 0, "R4 odd");
    par_en = 1'b0;
    // R5 one and a half and two stop bits, odd divisor
    clk_div = 20'd17; stop_len = 2'd2;
    run_frame(8'h3C, 0, "R5 1.5 stop");
    stop_len = 2'd3;
    run_frame(8'h3C, 0, "R5 2 stop");
    stop_len = 2'd0;
    run_frame(8'h81, 0, "R5 code 0");
    stop_len = 2'd1;
    // R6 divisor clamp
    clk_div = 20'd3;
    run_frame(8'h55, 0, "R6");
    clk_div = 20'd0;
    run_frame(8'h01, 0, "R6 zero");
    clk_div = 20'd16;
    // R7 inverted line
    line_inv = 1'b1;
    @(negedge clk);
    check(txd === 1'b0, "R7", "inverted idle", txd, 0);
    run_frame(8'h96, 0, "R7");
    line_inv = 1'b0;

    // R8 flow control blocks starts
    flow_en = 1'b1; cts_n = 1'b1; cts_inv = 1'b0;
    in_data = 8'h11; in_valid = 1'b1;
    begin
      bit ok = 1'b1;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (busy !== 1'b0 || txd !== 1'b1 || in_ready !== 1'b0) ok = 1'b0;
      end
      check(ok, "R8", "blocked start {ready,busy,txd}", {in_ready, busy, txd}, 3'b001);
    end
    // R8 inverted clear-to-send lets the held byte go
    cts_inv = 1'b1;
    run_frame(8'h11, 0, "R8 cts_inv");
    // R9 clear-to-send drops mid-frame, frame completes
    run_frame(8'hC3, 1, "R9");
    check(in_ready === 1'b0, "R9", "ready after frame with cts blocked", in_ready, 0);
    cts_n = 1'b0; cts_inv = 1'b0; flow_en = 1'b0;
    // R10 format change mid-frame
    data_len = 2'd1; stop_len = 2'd1; par_en = 1'b1; par_odd = 1'b0; clk_div = 20'd20;
    run_frame(8'h2D, 2, "R10");
    run_frame(8'h2D, 0, "R10 next frame");

    // R11 back-to-back frames, ready in the cycle after the stop time (checked in run_frame)
    data_len = 2'd3; stop_len = 2'd1; par_en = 1'b0; clk_div = 20'd16;
    run_frame(8'hF0, 0, "R11");
    run_frame(8'h0F, 0, "R11");

    // random mix: R2 R3 R4 R5 R6 R7
    for (int n = 0; n < 60; n++) begin
      data_len = 2'($urandom % 4);
      stop_len = 2'($urandom % 4);
      par_en = 1'($urandom % 2);
      par_odd = 1'($urandom % 2);
      line_inv = 1'($urandom % 2);
      clk_div = ($urandom % 8 == 0) ? 20'($urandom % 16) : 20'(16 + $urandom % 25);
      @(negedge clk);
      run_frame(8'($urandom), 0, "R2 R3 R4 R5 R6 R7 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule